// File: doc/BRIEF.md
# Low-Speed Real-Time Clock Register Block

This block keeps wall-clock time as a 32-bit seconds count plus a milliseconds count, advanced by a strobe that marks each edge of a slow reference clock, nominally 32768 Hz. A fractional divider turns these strobes into milliseconds. When milliseconds pass 999 they return to 0 and seconds advance. A register slave presents the time to the rest of the chip, along with two seconds alarms, a stored milliseconds-alarm value, an interrupt enable register, a pending register cleared by writing ones, and a level interrupt.

The register side does not show the running counters. Once every `POST_DIV` slow strobes, the block raises a busy flag for `BUSY_LEN` bus cycles. At the end of that window it copies the running seconds and milliseconds into the values that reads return. Writes that arrive while busy is set are accepted and discarded. Software therefore polls the busy flag and writes just after it drops. A milliseconds read also stores the seconds value shown at that moment into a shadow register. A later shadow read gives a seconds value that matches the milliseconds sample.

Requests arrive on a valid/ready channel. A request transfers on a cycle where `req_valid` and `req_ready` are both high. Each read transfer produces exactly one response on a second valid/ready channel. That response stays registered, unchanged, until `rsp_ready` takes it. While it is held, `req_ready` is low, so a stalled consumer stops further requests. Writes produce no response.

Top module: `rtc_lowspeed`

## Requirements
- R1: Each slow strobe adds 1000 to a phase accumulator, and milliseconds step by one whenever the accumulator reaches `TICK_HZ` (the excess is kept). After L strobes since a seconds load, the total elapsed milliseconds is floor(L*1000/TICK_HZ). Milliseconds stay within 0..999, and the step from 999 to 0 increments seconds, which wraps from 0xFFFFFFFF to 0.
- R2: A write to SEC (offset 0x00) loads the seconds counter and the visible seconds value at once. It clears milliseconds and the phase accumulator.
- R3: On every `POST_DIV`-th strobe, FLAGS (offset 0x0C) bit 0 reads 1 for the next `BUSY_LEN` cycles. At the end of that window, SEC and MSEC (offset 0x04) take the running values.
- R4: A write accepted while busy reads 1 has no effect on any register. Reads are accepted whether or not busy is set.
- R5: A read of MSEC stores the seconds value then visible into SHADOW (offset 0x08). SHADOW keeps it until the next MSEC read.
- R6: Pending bit a (a = 0 for ALM0 at 0x10, a = 1 for ALM1 at 0x14) is set on the cycle after the running seconds count becomes equal to a nonzero alarm value. Only the moment it becomes equal counts, and the enable value does not matter.
- R7: Writing PEND (offset 0x20) clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R8: `irq` is high exactly while some pending bit has its IENAB (offset 0x1C) bit set.
- R9: IENAB and PEND use five bits: 0 ALM0, 1 ALM1, 2 milliseconds alarm, 3 seconds countdown, 4 milliseconds countdown. The upper bits read 0. Bits 2 to 4 of PEND never set. MSALM (offset 0x18) only stores and returns a value.
- R10: A read response is held stable while `rsp_ready` is low, and `req_ready` stays low until that response is taken.
- R11: After reset, all registers read 0, busy is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe per slow reference clock edge |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the block with `TICK_HZ` = 1500, `POST_DIV` = 8 and `BUSY_LEN` = 4. At that rate one second is 1500 strobes, and milliseconds advance on two strobes out of every three. This exercises the fractional carry, the milliseconds-to-seconds rollover, an alarm firing and the 32-bit seconds wrap, all within a few thousand cycles. Every strobe burst ends on a multiple of eight. The busy window and the dropped writes can then be hit on a known cycle, and the visible time can be predicted exactly from the strobe count.

// File: rtl/rtc_ls_pkg.sv
package rtc_ls_pkg;
  localparam int WORD_W      = 32;
  localparam int MS_PER_S    = 1000;
  localparam int MS_W        = $clog2(MS_PER_S);
  localparam int EVT_W       = 5;
  localparam int NUM_SEC_ALM = 2;

  // event bit positions shared by IENAB and PEND
  localparam int EVB_ALM0  = 0;
  localparam int EVB_ALM1  = 1;
  localparam int EVB_MSALM = 2;
  localparam int EVB_SCD   = 3;
  localparam int EVB_MSCD  = 4;

  // register byte offsets
  localparam logic [7:0] OFS_SEC    = 8'h00;
  localparam logic [7:0] OFS_MSEC   = 8'h04;
  localparam logic [7:0] OFS_SHADOW = 8'h08;
  localparam logic [7:0] OFS_FLAGS  = 8'h0C;
  localparam logic [7:0] OFS_ALM0   = 8'h10;
  localparam logic [7:0] OFS_ALM1   = 8'h14;
  localparam logic [7:0] OFS_MSALM  = 8'h18;
  localparam logic [7:0] OFS_IENAB  = 8'h1C;
  localparam logic [7:0] OFS_PEND   = 8'h20;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [MS_W-1:0]   ms_t;
  typedef logic [EVT_W-1:0]  evt_t;
endpackage

// File: rtl/rtc_ls_timebase.sv
module rtc_ls_timebase
  import rtc_ls_pkg::*;
#(
  parameter int TICK_HZ = 32768
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  load,
  input  word_t load_val,
  output word_t sec,
  output ms_t   ms
);
  localparam int ACC_W = $clog2(TICK_HZ + MS_PER_S + 1);

  logic [ACC_W-1:0] acc_q, acc_sum;
  logic             step;

  always_comb begin
    acc_sum = acc_q + ACC_W'(MS_PER_S);
    step    = (acc_sum >= ACC_W'(TICK_HZ));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ms    <= '0;
      sec   <= '0;
    end else if (load) begin
      acc_q <= '0;
      ms    <= '0;
      sec   <= load_val;
    end else if (tick) begin
      acc_q <= step ? (acc_sum - ACC_W'(TICK_HZ)) : acc_sum;
      if (step) begin
        if (ms == ms_t'(MS_PER_S - 1)) begin
          ms  <= '0;
          sec <= sec + 1'b1;
        end else begin
          ms <= ms + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_ls_post.sv
module rtc_ls_post
  import rtc_ls_pkg::*;
#(
  parameter int POST_DIV = 8,
  parameter int BUSY_LEN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  load,
  input  word_t load_val,
  input  word_t live_sec,
  input  ms_t   live_ms,
  output logic  busy,
  output word_t view_sec,
  output ms_t   view_ms
);
  localparam int PC_W = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;
  localparam int BC_W = $clog2(BUSY_LEN + 1);

  logic [PC_W-1:0] pcnt_q;
  logic [BC_W-1:0] bcnt_q;
  logic            post;

  assign post = tick && (pcnt_q == PC_W'(POST_DIV - 1));
  assign busy = (bcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      if (tick) pcnt_q <= post ? '0 : pcnt_q + 1'b1;
      if (post)        bcnt_q <= BC_W'(BUSY_LEN);
      else if (busy)   bcnt_q <= bcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_sec <= '0;
      view_ms  <= '0;
    end else if (load) begin
      view_sec <= load_val;
      view_ms  <= '0;
    end else if (bcnt_q == BC_W'(1)) begin
      view_sec <= live_sec;
      view_ms  <= live_ms;
    end
  end
endmodule

// File: rtl/rtc_ls_regs.sv
module rtc_ls_regs
  import rtc_ls_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  word_t                   req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output word_t                   rsp_rdata,
  input  logic                    busy,
  input  word_t                   view_sec,
  input  ms_t                     view_ms,
  input  word_t                   live_sec,
  output logic                    sec_load,
  output word_t                   sec_load_val,
  output word_t [NUM_SEC_ALM-1:0] alarm_q,
  output word_t                   shadow_q,
  output evt_t                    mask_q,
  output evt_t                    status_q,
  output logic                    irq
);
  logic acc_fire, wr_ok, rd_fire;
  logic [NUM_SEC_ALM-1:0] match, match_q;
  word_t msalm_q, rd_mux;
  evt_t  set_v, clr_v;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc_fire  = req_valid && req_ready;
  assign wr_ok     = acc_fire && req_write && !busy;
  assign rd_fire   = acc_fire && !req_write;

  assign sec_load     = wr_ok && hit(req_addr, OFS_SEC);
  assign sec_load_val = req_wdata;

  for (genvar a = 0; a < NUM_SEC_ALM; a++) begin : g_alm
    localparam logic [7:0] A_OFS = OFS_ALM0 + 8'(4 * a);
    assign match[a] = (live_sec == alarm_q[a]) && (alarm_q[a] != '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        alarm_q[a] <= '0;
      else if (wr_ok && hit(req_addr, A_OFS)) alarm_q[a] <= req_wdata;
    end
  end

  always_comb begin
    set_v = '0;
    set_v[NUM_SEC_ALM-1:0] = match & ~match_q;
    clr_v = (wr_ok && hit(req_addr, OFS_PEND)) ? req_wdata[EVT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      status_q <= '0;
      mask_q   <= '0;
      msalm_q  <= '0;
      shadow_q <= '0;
    end else begin
      match_q  <= match;
      status_q <= (status_q & ~clr_v) | set_v;
      if (wr_ok && hit(req_addr, OFS_IENAB)) mask_q  <= req_wdata[EVT_W-1:0];
      if (wr_ok && hit(req_addr, OFS_MSALM)) msalm_q <= req_wdata;
      if (rd_fire && hit(req_addr, OFS_MSEC)) shadow_q <= view_sec;
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (hit(req_addr, OFS_SEC))    rd_mux = view_sec;
    else if (hit(req_addr, OFS_MSEC))   rd_mux = word_t'(view_ms);
    else if (hit(req_addr, OFS_SHADOW)) rd_mux = shadow_q;
    else if (hit(req_addr, OFS_FLAGS))  rd_mux = word_t'(busy);
    else if (hit(req_addr, OFS_ALM0))   rd_mux = alarm_q[0];
    else if (hit(req_addr, OFS_ALM1))   rd_mux = alarm_q[NUM_SEC_ALM-1];
    else if (hit(req_addr, OFS_MSALM))  rd_mux = msalm_q;
    else if (hit(req_addr, OFS_IENAB))  rd_mux = word_t'(mask_q);
    else if (hit(req_addr, OFS_PEND))   rd_mux = word_t'(status_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign irq = |(status_q & mask_q);
endmodule

// File: rtl/rtc_lowspeed.sv
module rtc_lowspeed
  import rtc_ls_pkg::*;
#(
  parameter int TICK_HZ  = 32768,
  parameter int POST_DIV = 8,
  parameter int BUSY_LEN = 4,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);
  word_t live_sec, view_sec, sec_load_val, shadow_q;
  ms_t   live_ms, view_ms;
  logic  busy, sec_load;
  evt_t  mask_q, status_q;
  word_t [NUM_SEC_ALM-1:0] alarm_q;

  rtc_ls_timebase #(.TICK_HZ(TICK_HZ)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .load(sec_load),
    .load_val(sec_load_val), .sec(live_sec), .ms(live_ms)
  );

  rtc_ls_post #(.POST_DIV(POST_DIV), .BUSY_LEN(BUSY_LEN)) u_post (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .load(sec_load),
    .load_val(sec_load_val), .live_sec(live_sec), .live_ms(live_ms),
    .busy(busy), .view_sec(view_sec), .view_ms(view_ms)
  );

  rtc_ls_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .busy(busy), .view_sec(view_sec), .view_ms(view_ms), .live_sec(live_sec),
    .sec_load(sec_load), .sec_load_val(sec_load_val),
    .alarm_q(alarm_q), .shadow_q(shadow_q), .mask_q(mask_q),
    .status_q(status_q), .irq(irq)
  );
endmodule

// File: rtl/rtc_lowspeed_chk.sv
module rtc_lowspeed_chk
  import rtc_ls_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_i,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_write,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [31:0]             rsp_rdata,
  input logic                    irq,
  input logic                    busy,
  input ms_t                     live_ms,
  input word_t                   view_sec,
  input word_t                   shadow_q,
  input word_t [NUM_SEC_ALM-1:0] alarm_q,
  input evt_t                    mask_q,
  input evt_t                    status_q
);
  p_ms_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    live_ms < ms_t'(MS_PER_S));

  p_busy_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick_i));

  p_busy_drops_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && busy) |=> ($stable(alarm_q) && $stable(mask_q)));

  p_shadow_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == ADDR_W'(OFS_MSEC))
      |=> shadow_q == $past(view_sec));

  p_alarm_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[EVB_ALM0]) |-> alarm_q[0] != '0);

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q != '0);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_rsp_follows_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

bind rtc_lowspeed rtc_lowspeed_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .irq(irq), .busy(busy), .live_ms(live_ms),
  .view_sec(view_sec), .shadow_q(shadow_q), .alarm_q(alarm_q),
  .mask_q(mask_q), .status_q(status_q)
);

// File: tb/rtc_lowspeed_tb.sv
module rtc_lowspeed_tb;
  localparam int TB_HZ = 1500;
  localparam logic [7:0] A_SEC = 8'h00, A_MSEC = 8'h04, A_SHD = 8'h08, A_FLG = 8'h0C,
                         A_AL0 = 8'h10, A_AL1 = 8'h14, A_MSA = 8'h18, A_IEN = 8'h1C,
                         A_PND = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int n_vec = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_exp;
  string       m_tag;

  always #5 clk = ~clk;

  rtc_lowspeed #(.TICK_HZ(TB_HZ), .POST_DIV(8), .BUSY_LEN(4), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every response handshake
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
      end else begin
        m_exp = exp_q.pop_front();
        m_tag = tag_q.pop_front();
        chk(rsp_rdata === m_exp, m_tag, rsp_rdata, m_exp);
      end
    end
  end

  task automatic put(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic get(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      tick_i = 1'b1;
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R11 reset state
    chk(irq === 1'b0, "R11 irq after reset", 32'(irq), 32'h0);
    get(A_SEC, 32'h0, "R11 SEC reset");
    get(A_MSEC, 32'h0, "R11 MSEC reset");
    get(A_FLG, 32'h0, "R11 FLAGS reset");
    get(A_PND, 32'h0, "R11 PEND reset");
    get(A_IEN, 32'h0, "R11 IENAB reset");
    get(A_AL0, 32'h0, "R11 ALM0 reset");

    // R2 load seconds
    put(A_SEC, 32'd100);
    get(A_SEC, 32'd100, "R2 SEC after load");
    get(A_MSEC, 32'd0, "R2 MSEC cleared by load");

    // R1 fractional milliseconds: 24 strobes -> 16 ms
    ticks(24); idle(8);
    get(A_MSEC, 32'd16, "R1 MSEC after 24 strobes");
    get(A_SEC, 32'd100, "R1 SEC unchanged");

    // R3 busy window right after 8th strobe (L=32 -> 21 ms)
    ticks(8);
    get(A_FLG, 32'h1, "R3 FLAGS busy after post");
    idle(8);
    get(A_FLG, 32'h0, "R3 FLAGS idle");
    get(A_MSEC, 32'd21, "R3 MSEC posted");

    // R4 writes dropped while busy
    ticks(8);
    put(A_AL1, 32'd55);
    idle(8);
    get(A_AL1, 32'd0, "R4 ALM1 write while busy dropped");
    put(A_AL1, 32'd55);
    get(A_AL1, 32'd55, "R4 ALM1 write when idle");
    ticks(8);
    put(A_SEC, 32'd7);
    idle(8);
    get(A_SEC, 32'd100, "R4 SEC write while busy dropped");

    // R5 shadow; L=48 -> 32 ms; then 1504 strobes -> L=1552 -> 1034 ms total
    get(A_MSEC, 32'd32, "R5 MSEC sample");
    ticks(1504); idle(8);
    get(A_SHD, 32'd100, "R5 SHADOW holds sampled seconds");
    get(A_SEC, 32'd101, "R1 SEC after ms rollover");
    get(A_MSEC, 32'd34, "R1 MSEC after rollover");
    get(A_SHD, 32'd101, "R5 SHADOW refreshed by MSEC read");

    // R6/R8 alarm 0 with enable; L=3000 -> sec 102 ms 0
    put(A_IEN, 32'h1);
    put(A_AL0, 32'd102);
    idle(2);
    chk(irq === 1'b0, "R8 irq low before alarm", 32'(irq), 32'h0);
    ticks(1448); idle(8);
    chk(irq === 1'b1, "R8 irq on enabled alarm", 32'(irq), 32'h1);
    get(A_PND, 32'h1, "R6 PEND bit0 on alarm");
    get(A_SEC, 32'd102, "R1 SEC at alarm time");
    get(A_MSEC, 32'd0, "R1 MSEC at alarm time");

    // R7 write-one-to-clear
    put(A_PND, 32'h0);
    get(A_PND, 32'h1, "R7 PEND write 0 keeps bit");
    put(A_PND, 32'h1);
    idle(1);
    chk(irq === 1'b0, "R8 irq drops after clear", 32'(irq), 32'h0);
    get(A_PND, 32'h0, "R7 PEND cleared and not re-set");

    // R6 mask independence on alarm 1
    put(A_AL1, 32'd102);
    idle(2);
    chk(irq === 1'b0, "R8 irq stays low when disabled", 32'(irq), 32'h0);
    get(A_PND, 32'h2, "R6 PEND bit1 set while disabled");
    put(A_IEN, 32'h3);
    idle(1);
    chk(irq === 1'b1, "R8 irq on enable of pending", 32'(irq), 32'h1);
    put(A_PND, 32'h2);
    idle(1);
    chk(irq === 1'b0, "R7 irq after clearing bit1", 32'(irq), 32'h0);

    // R1 32-bit wrap and R6 zero alarm never fires
    put(A_AL0, 32'h0);
    put(A_AL1, 32'h0);
    put(A_SEC, 32'hFFFF_FFFF);
    ticks(1504); idle(8);
    get(A_SEC, 32'h0, "R1 SEC wraps to 0");
    get(A_MSEC, 32'd2, "R1 MSEC after wrap");
    get(A_PND, 32'h0, "R6 zero alarm does not fire");

    // R9 field widths and stored-only register
    put(A_MSA, 32'd500);
    get(A_MSA, 32'd500, "R9 MSALM stored");
    put(A_IEN, 32'hFF);
    get(A_IEN, 32'h1F, "R9 IENAB five bits");
    get(A_PND, 32'h0, "R9 other event bits never set");
    idle(1);
    chk(irq === 1'b0, "R9 irq with no pending", 32'(irq), 32'h0);

    // R10 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    get(A_MSA, 32'd500, "R10 held response data");
    chk(rsp_valid === 1'b1, "R10 response held", 32'(rsp_valid), 32'h1);
    chk(req_ready === 1'b0, "R10 req_ready low while held", 32'(req_ready), 32'h0);
    idle(2);
    chk(req_ready === 1'b0, "R10 req_ready still low", 32'(req_ready), 32'h0);
    @(negedge clk); rsp_ready = 1'b1;
    idle(3);
    chk(req_ready === 1'b1, "R10 req_ready back after take", 32'(req_ready), 32'h1);
    put(A_MSA, 32'd9);
    chk(rsp_valid === 1'b0, "R10 write makes no response", 32'(rsp_valid), 32'h0);

    idle(4);
    chk(exp_q.size() == 0, "R10 all responses received", 32'(exp_q.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule